// File: doc/BRIEF.md
# GPIO Configuration Register Bank with Keyed Write Protection

This block holds the software-visible configuration of a 32-pin general purpose I/O port. It has a word-wide register access port and exports every configuration vector straight to the pin logic. Reads are registered: `rdData` holds the result in the cycle after the one in which `rdEn` was sampled. Writes take effect at the clock edge that samples `wrEn`.

The bank can be write-protected. Any write to either of the two key words arms the protection. Once armed, only the second key word accepts data. The protection comes off only when the second key word already holds one magic value and the first key word is then written with a different magic value. The drive-level, output-enable and event-mask registers each have a set alias and a clear alias, so single bits can be changed without a read-modify-write. A sticky event-flag register is set by hit pulses from the pin logic and cleared by writing ones to it. Any access the bank refuses raises a one-cycle error pulse.

Top module: `gpio_cfg_bank`

## Requirements
- R1: After reset the pull-up (0x1C), pull-down (0x20), slew (0x5C) and strength (0x60) words hold their per-instance reset parameters. Every other word reads 0, and `locked` is 0.
- R2: While unlocked, a write to a storage word replaces its contents. The storage words are 0x08 invert, 0x0C drive level, 0x10 output enable, 0x14 open drain, 0x18 mux, 0x1C, 0x20, 0x24 filter, 0x28 event kind, 0x2C both edges, 0x30 to 0x3C flash, 0x40 event mask, 0x58 input gate, 0x5C and 0x60. The new value is readable and visible on its `cfg*` port from the next cycle.
- R3: While unlocked, any write to 0x00 or 0x7C locks the bank: `locked` rises and word 0x00 reads 1.
- R4: While locked, a write to any word other than 0x00 and 0x7C changes nothing and pulses `accErr`.
- R5: While locked, a write of 0xC0DEFA73 to 0x00 unlocks the bank only if 0x7C holds 0xC0DE1248. Unlocking zeroes both key words. A write to 0x7C while locked stores its value without error. A refused unlock write leaves the bank locked and pulses `accErr`.
- R6: Writing to a set alias ORs the data into its target register. Writing to a clear alias clears the data's one bits in the target. The aliases are 0x68 set and 0x6C clear for drive level, 0x70 set and 0x74 clear for output enable, and 0x44 set and 0x48 clear for event mask.
- R7: Each cycle, one bits on `evHit` set the matching bits of the event flags (0x4C). A write to 0x4C clears the flags where the data has ones. A hit in the same cycle as a clear wins.
- R8: Reads of the write-only words 0x44, 0x48, 0x68, 0x6C, 0x70, 0x74 and 0x7C return 0 and pulse `accErr`.
- R9: Word 0x04 reads the current `pinIn`. A write to it is refused with `accErr`.
- R10: Accesses outside the 128-byte window, or with a nonzero low address pair, read 0, change nothing and pulse `accErr`. The same holds for the unused words 0x50, 0x54, 0x64 and 0x78.
- R11: `accErr` is high for exactly the cycle after a refused access and low after an accepted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request |
| rdEn | input | 1 | Read request |
| addr | input | ADDR_W | Byte address |
| wrData | input | 32 | Write data |
| pinIn | input | 32 | Pin levels from the pin logic |
| evHit | input | 32 | Event hit pulses from the pin logic |
| rdData | output | 32 | Registered read data |
| accErr | output | 1 | One-cycle refused-access pulse |
| locked | output | 1 | Write protection active |
| cfgInvert | output | 32 | Per-pin polarity inversion |
| cfgDrive | output | 32 | Drive level |
| cfgOutEn | output | 32 | Output enable |
| cfgOpenDrain | output | 32 | Open-drain output type |
| cfgPullUp | output | 32 | Pull-up enable |
| cfgPullDown | output | 32 | Pull-down enable |
| cfgInGate | output | 32 | Input enable mask |
| cfgEvKind | output | 32 | Event kind (level or edge) |
| cfgEvBoth | output | 32 | Both-edge event select |
| cfgEvMask | output | 32 | Event enable |
| cfgEvFlag | output | 32 | Sticky event flags |
| cfgSlew | output | 32 | Slew-rate select |
| cfgStrength | output | 32 | Drive-strength select |

## Verification
The properties assume that `wrEn` and `rdEn` stay low while reset is held, so no past-value check sees a pre-reset request. They also assume that all inputs carry known values at every sampled edge. The bench meets both conditions: it holds all requests low through reset, changes inputs only on falling edges, and issues at most one access per request cycle, each followed by an idle cycle. That spacing makes every `accErr` pulse attributable to exactly one access.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DW     = 32;
  localparam int IDXW   = 5;
  localparam int NWORDS = 1 << IDXW;

  localparam logic [IDXW-1:0] W_KEYA     = 5'd0;
  localparam logic [IDXW-1:0] W_PINS     = 5'd1;
  localparam logic [IDXW-1:0] W_INVERT   = 5'd2;
  localparam logic [IDXW-1:0] W_DRIVE    = 5'd3;
  localparam logic [IDXW-1:0] W_OUTEN    = 5'd4;
  localparam logic [IDXW-1:0] W_ODRAIN   = 5'd5;
  localparam logic [IDXW-1:0] W_PULLHI   = 5'd7;
  localparam logic [IDXW-1:0] W_PULLLO   = 5'd8;
  localparam logic [IDXW-1:0] W_EVKIND   = 5'd10;
  localparam logic [IDXW-1:0] W_EVBOTH   = 5'd11;
  localparam logic [IDXW-1:0] W_EVMASK   = 5'd16;
  localparam logic [IDXW-1:0] W_EVMSET   = 5'd17;
  localparam logic [IDXW-1:0] W_EVMCLR   = 5'd18;
  localparam logic [IDXW-1:0] W_EVFLAG   = 5'd19;
  localparam logic [IDXW-1:0] W_INGATE   = 5'd22;
  localparam logic [IDXW-1:0] W_SLEW     = 5'd23;
  localparam logic [IDXW-1:0] W_STRENGTH = 5'd24;
  localparam logic [IDXW-1:0] W_DRVSET   = 5'd26;
  localparam logic [IDXW-1:0] W_DRVCLR   = 5'd27;
  localparam logic [IDXW-1:0] W_OESET    = 5'd28;
  localparam logic [IDXW-1:0] W_OECLR    = 5'd29;
  localparam logic [IDXW-1:0] W_KEYB     = 5'd31;

  localparam logic [DW-1:0] KEY_OPEN = 32'hC0DE_FA73;
  localparam logic [DW-1:0] KEY_ARM  = 32'hC0DE_1248;

  typedef enum logic [2:0] {
    K_NONE, K_RO, K_PLAIN, K_SETA, K_CLRA, K_W1C, K_KEY
  } wordKind_t;

  typedef struct packed {
    logic            store;
    logic            orIn;
    logic            andNotIn;
    logic [IDXW-1:0] idx;
    logic            lockNow;
    logic            unlockNow;
    logic            keyBWrite;
    logic            rdLoad;
    logic            rdZero;
    logic [IDXW-1:0] rdIdx;
  } bankStrobes_t;

  function automatic wordKind_t kindOf(logic [IDXW-1:0] i);
    if (i == W_KEYA || i == W_KEYB) return K_KEY;
    if (i == W_PINS) return K_RO;
    if ((i >= W_INVERT && i <= W_EVMASK) || (i >= W_INGATE && i <= W_STRENGTH)) return K_PLAIN;
    if (i == W_EVMSET || i == W_DRVSET || i == W_OESET) return K_SETA;
    if (i == W_EVMCLR || i == W_DRVCLR || i == W_OECLR) return K_CLRA;
    if (i == W_EVFLAG) return K_W1C;
    return K_NONE;
  endfunction

  function automatic logic [IDXW-1:0] aliasTarget(logic [IDXW-1:0] i);
    if (i == W_DRVSET || i == W_DRVCLR) return W_DRIVE;
    if (i == W_OESET || i == W_OECLR) return W_OUTEN;
    if (i == W_EVMSET || i == W_EVMCLR) return W_EVMASK;
    return i;
  endfunction
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wrData,
  input  logic              lockBit,
  input  logic [DW-1:0]     keyBHeld,
  output bankStrobes_t      stb,
  output logic              accErr
);
  localparam int WIN_W = IDXW + 2;

  logic            inRange;
  logic [IDXW-1:0] idx;
  wordKind_t       kind;
  logic            wrErr;
  logic            rdErr;

  assign inRange = (addr[1:0] == 2'b00) && ((addr >> WIN_W) == '0);
  assign idx     = addr[WIN_W-1:2];
  assign kind    = kindOf(idx);

  always_comb begin
    stb   = '0;
    wrErr = 1'b0;
    rdErr = 1'b0;
    if (wrEn) begin
      if (!inRange) begin
        wrErr = 1'b1;
      end else if (lockBit) begin
        if (idx == W_KEYA) begin
          if (wrData == KEY_OPEN && keyBHeld == KEY_ARM) stb.unlockNow = 1'b1;
          else wrErr = 1'b1;
        end else if (idx == W_KEYB) begin
          stb.keyBWrite = 1'b1;
        end else begin
          wrErr = 1'b1;
        end
      end else begin
        case (kind)
          K_KEY:   stb.lockNow = 1'b1;
          K_PLAIN: begin stb.store = 1'b1; stb.idx = idx; end
          K_SETA:  begin stb.orIn = 1'b1; stb.idx = aliasTarget(idx); end
          K_CLRA, K_W1C: begin stb.andNotIn = 1'b1; stb.idx = aliasTarget(idx); end
          default: wrErr = 1'b1;
        endcase
      end
    end
    if (rdEn) begin
      stb.rdLoad = 1'b1;
      stb.rdIdx  = idx;
      if (!inRange || idx == W_KEYB || kind == K_NONE || kind == K_SETA || kind == K_CLRA) begin
        stb.rdZero = 1'b1;
        rdErr      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) accErr <= 1'b0;
    else       accErr <= wrErr | rdErr;
  end
endmodule

// File: rtl/gpio_bank_data.sv
module gpio_bank_data
  import gpio_bank_pkg::*;
#(
  parameter logic [DW-1:0] RST_PULLUP   = '0,
  parameter logic [DW-1:0] RST_PULLDOWN = '0,
  parameter logic [DW-1:0] RST_SLEW     = '0,
  parameter logic [DW-1:0] RST_STRENGTH = '0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bankStrobes_t               stb,
  input  logic [DW-1:0]              wrData,
  input  logic [DW-1:0]              pinIn,
  input  logic [DW-1:0]              evHit,
  output logic                       lockBit,
  output logic [DW-1:0]              keyBHeld,
  output logic [DW-1:0]              rdData,
  output logic [NWORDS-1:0][DW-1:0]  regs
);
  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    localparam logic [IDXW-1:0] IDX  = IDXW'(i);
    localparam wordKind_t       KIND = kindOf(IDX);
    localparam logic [DW-1:0]   RV   =
      (IDX == W_PULLHI)   ? RST_PULLUP   :
      (IDX == W_PULLLO)   ? RST_PULLDOWN :
      (IDX == W_SLEW)     ? RST_SLEW     :
      (IDX == W_STRENGTH) ? RST_STRENGTH : '0;
    if (KIND == K_PLAIN || KIND == K_W1C) begin : g_reg
      logic          hit;
      logic [DW-1:0] q;
      logic [DW-1:0] nxt;
      logic [DW-1:0] setIn;
      assign hit   = (stb.idx == IDX);
      assign setIn = (KIND == K_W1C) ? evHit : '0;
      always_comb begin
        nxt = q;
        if (hit && stb.store)         nxt = wrData;
        else if (hit && stb.orIn)     nxt = q | wrData;
        else if (hit && stb.andNotIn) nxt = q & ~wrData;
      end
      always_ff @(posedge clk) begin
        if (!rstN) q <= RV;
        else       q <= nxt | setIn;
      end
      assign regs[i] = q;
    end else begin : g_none
      assign regs[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockBit  <= 1'b0;
      keyBHeld <= '0;
    end else if (stb.lockNow || stb.unlockNow) begin
      lockBit  <= stb.lockNow;
      keyBHeld <= '0;
    end else if (stb.keyBWrite) begin
      keyBHeld <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdLoad) begin
      if (stb.rdZero)               rdData <= '0;
      else if (stb.rdIdx == W_KEYA) rdData <= {{(DW-1){1'b0}}, lockBit};
      else if (stb.rdIdx == W_PINS) rdData <= pinIn;
      else                          rdData <= regs[stb.rdIdx];
    end
  end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_bank_pkg::*;
#(
  parameter int            ADDR_W       = 12,
  parameter logic [31:0]   RST_PULLUP   = '0,
  parameter logic [31:0]   RST_PULLDOWN = '0,
  parameter logic [31:0]   RST_SLEW     = '0,
  parameter logic [31:0]   RST_STRENGTH = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic [31:0]       pinIn,
  input  logic [31:0]       evHit,
  output logic [31:0]       rdData,
  output logic              accErr,
  output logic              locked,
  output logic [31:0]       cfgInvert,
  output logic [31:0]       cfgDrive,
  output logic [31:0]       cfgOutEn,
  output logic [31:0]       cfgOpenDrain,
  output logic [31:0]       cfgPullUp,
  output logic [31:0]       cfgPullDown,
  output logic [31:0]       cfgInGate,
  output logic [31:0]       cfgEvKind,
  output logic [31:0]       cfgEvBoth,
  output logic [31:0]       cfgEvMask,
  output logic [31:0]       cfgEvFlag,
  output logic [31:0]       cfgSlew,
  output logic [31:0]       cfgStrength
);
  bankStrobes_t              stb;
  logic                      lockBit;
  logic [DW-1:0]             keyBHeld;
  logic [NWORDS-1:0][DW-1:0] regs;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .lockBit(lockBit), .keyBHeld(keyBHeld),
    .stb(stb), .accErr(accErr)
  );

  gpio_bank_data #(
    .RST_PULLUP(RST_PULLUP), .RST_PULLDOWN(RST_PULLDOWN),
    .RST_SLEW(RST_SLEW), .RST_STRENGTH(RST_STRENGTH)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .pinIn(pinIn),
    .evHit(evHit), .lockBit(lockBit), .keyBHeld(keyBHeld),
    .rdData(rdData), .regs(regs)
  );

  assign locked       = lockBit;
  assign cfgInvert    = regs[W_INVERT];
  assign cfgDrive     = regs[W_DRIVE];
  assign cfgOutEn     = regs[W_OUTEN];
  assign cfgOpenDrain = regs[W_ODRAIN];
  assign cfgPullUp    = regs[W_PULLHI];
  assign cfgPullDown  = regs[W_PULLLO];
  assign cfgInGate    = regs[W_INGATE];
  assign cfgEvKind    = regs[W_EVKIND];
  assign cfgEvBoth    = regs[W_EVBOTH];
  assign cfgEvMask    = regs[W_EVMASK];
  assign cfgEvFlag    = regs[W_EVFLAG];
  assign cfgSlew      = regs[W_SLEW];
  assign cfgStrength  = regs[W_STRENGTH];
endmodule

// File: rtl/gpio_cfg_bank_chk.sv
module gpio_cfg_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [31:0]       evHit,
  input logic              accErr,
  input logic              locked,
  input logic [31:0]       cfgInvert,
  input logic [31:0]       cfgDrive,
  input logic [31:0]       cfgOutEn,
  input logic [31:0]       cfgEvFlag
);
  logic keyWord;
  assign keyWord = (addr == ADDR_W'(0)) || (addr == ADDR_W'(32'h7C));

  // R3
  arm_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && wrEn && keyWord) |=> locked);

  // R4
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && wrEn && !keyWord) |=> accErr && $stable(cfgDrive) && $stable(cfgOutEn) && $stable(cfgInvert));

  // R5
  unlock_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> ($past(wrEn) && $past(addr) == ADDR_W'(0) && $past(wrData) == KEY_OPEN));

  // R6
  drive_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && wrEn && addr == ADDR_W'(32'h68)) |=> cfgDrive == ($past(cfgDrive) | $past(wrData)));

  // R6
  oe_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && wrEn && addr == ADDR_W'(32'h74)) |=> cfgOutEn == ($past(cfgOutEn) & ~$past(wrData)));

  // R7
  hit_sticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evHit != '0) |=> ((cfgEvFlag & $past(evHit)) == $past(evHit)));

  // R11
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> $past(wrEn || rdEn));
endmodule

bind gpio_cfg_bank gpio_cfg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .evHit(evHit), .accErr(accErr), .locked(locked),
  .cfgInvert(cfgInvert), .cfgDrive(cfgDrive), .cfgOutEn(cfgOutEn),
  .cfgEvFlag(cfgEvFlag)
);

// File: tb/tb_gpio_cfg_bank.sv
module tb_gpio_cfg_bank;
  localparam logic [31:0] P_UP  = 32'h0000_F00F;
  localparam logic [31:0] P_DN  = 32'h00FF_0000;
  localparam logic [31:0] P_SLW = 32'h1234_5678;
  localparam logic [31:0] P_STR = 32'h8000_0001;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, wrEn, rdEn;
  logic [11:0] addr;
  logic [31:0] wrData, pinIn, evHit, rdData;
  logic        accErr, locked;
  logic [31:0] cfgInvert, cfgDrive, cfgOutEn, cfgOpenDrain, cfgPullUp, cfgPullDown;
  logic [31:0] cfgInGate, cfgEvKind, cfgEvBoth, cfgEvMask, cfgEvFlag, cfgSlew, cfgStrength;

  gpio_cfg_bank #(.ADDR_W(12), .RST_PULLUP(P_UP), .RST_PULLDOWN(P_DN),
                  .RST_SLEW(P_SLW), .RST_STRENGTH(P_STR)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .pinIn(pinIn), .evHit(evHit), .rdData(rdData), .accErr(accErr), .locked(locked),
    .cfgInvert(cfgInvert), .cfgDrive(cfgDrive), .cfgOutEn(cfgOutEn),
    .cfgOpenDrain(cfgOpenDrain), .cfgPullUp(cfgPullUp), .cfgPullDown(cfgPullDown),
    .cfgInGate(cfgInGate), .cfgEvKind(cfgEvKind), .cfgEvBoth(cfgEvBoth),
    .cfgEvMask(cfgEvMask), .cfgEvFlag(cfgEvFlag), .cfgSlew(cfgSlew),
    .cfgStrength(cfgStrength)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [32];
  logic        lockM;
  logic [31:0] keyBM;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit storeWord(int i);
    return (i >= 2 && i <= 16) || (i >= 22 && i <= 24);
  endfunction

  function automatic bit woWord(int i);
    return i == 17 || i == 18 || (i >= 26 && i <= 29) || i == 31;
  endfunction

  function automatic bit okAddr(logic [11:0] a);
    return a[1:0] == 2'b00 && a[11:7] == 5'd0;
  endfunction

  task automatic modelWr(input logic [11:0] a, input logic [31:0] d, output bit e);
    int i;
    i = int'(a[6:2]);
    e = 1'b0;
    if (!okAddr(a)) e = 1'b1;
    else if (lockM) begin
      if (i == 0) begin
        if (d == 32'hC0DE_FA73 && keyBM == 32'hC0DE_1248) begin lockM = 1'b0; keyBM = 0; end
        else e = 1'b1;
      end else if (i == 31) keyBM = d;
      else e = 1'b1;
    end else begin
      if (i == 0 || i == 31) begin lockM = 1'b1; keyBM = 0; end
      else if (storeWord(i)) mdl[i] = d;
      else if (i == 17) mdl[16] = mdl[16] | d;
      else if (i == 18) mdl[16] = mdl[16] & ~d;
      else if (i == 19) mdl[19] = mdl[19] & ~d;
      else if (i == 26) mdl[3] = mdl[3] | d;
      else if (i == 27) mdl[3] = mdl[3] & ~d;
      else if (i == 28) mdl[4] = mdl[4] | d;
      else if (i == 29) mdl[4] = mdl[4] & ~d;
      else e = 1'b1;
    end
  endtask

  task automatic modelRd(input logic [11:0] a, output logic [31:0] v, output bit e);
    int i;
    i = int'(a[6:2]);
    v = 0;
    e = 1'b0;
    if (!okAddr(a)) e = 1'b1;
    else if (i == 0) v = {31'd0, lockM};
    else if (i == 1) v = pinIn;
    else if (storeWord(i) || i == 19) v = mdl[i];
    else e = 1'b1;
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d, input string tag);
    bit e;
    modelWr(a, d, e);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    chk({tag, " err after write"}, {31'd0, accErr}, {31'd0, e});
    chk("R3 R5 lock state", {31'd0, locked}, {31'd0, lockM});
  endtask

  task automatic doRead(input logic [11:0] a, input string tag);
    bit e;
    logic [31:0] v;
    @(negedge clk);
    modelRd(a, v, e);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    chk({tag, " read data"}, rdData, v);
    chk("R11 err after read", {31'd0, accErr}, {31'd0, e});
  endtask

  task automatic readAll(input string tag);
    for (int i = 0; i < 32; i++) doRead(12'(i * 4), tag);
  endtask

  task automatic chkPorts(input string tag);
    chk({tag, " invert"}, cfgInvert, mdl[2]);
    chk({tag, " drive"}, cfgDrive, mdl[3]);
    chk({tag, " outen"}, cfgOutEn, mdl[4]);
    chk({tag, " opendrain"}, cfgOpenDrain, mdl[5]);
    chk({tag, " pullup"}, cfgPullUp, mdl[7]);
    chk({tag, " pulldown"}, cfgPullDown, mdl[8]);
    chk({tag, " evkind"}, cfgEvKind, mdl[10]);
    chk({tag, " evboth"}, cfgEvBoth, mdl[11]);
    chk({tag, " evmask"}, cfgEvMask, mdl[16]);
    chk({tag, " evflag"}, cfgEvFlag, mdl[19]);
    chk({tag, " ingate"}, cfgInGate, mdl[22]);
    chk({tag, " slew"}, cfgSlew, mdl[23]);
    chk({tag, " strength"}, cfgStrength, mdl[24]);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0;
    pinIn = 32'h5A5A_1234; evHit = '0;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    mdl[7] = P_UP; mdl[8] = P_DN; mdl[23] = P_SLW; mdl[24] = P_STR;
    lockM = 1'b0; keyBM = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset contents
    chk("R1 locked at reset", {31'd0, locked}, 32'd0);
    chkPorts("R1 ports");
    readAll("R1 R8 R9 R10");

    // R2 store sweep over every non-key word
    for (int i = 1; i < 31; i++) doWrite(12'(i * 4), 32'h9E37_79B9 * 32'(i + 1), "R2 R9 R10");
    readAll("R2");
    chkPorts("R2 ports");

    // R9 din follows pins
    pinIn = 32'hC3C3_0F0F;
    doRead(12'h004, "R9");

    // R6 alias writes
    doWrite(12'h00C, 32'h0000_0000, "R2");
    doWrite(12'h068, 32'h0F0F_00FF, "R6");
    doWrite(12'h06C, 32'h0000_000F, "R6");
    doWrite(12'h010, 32'hFFFF_0000, "R2");
    doWrite(12'h074, 32'h00FF_0000, "R6");
    doWrite(12'h070, 32'h0000_0003, "R6");
    doWrite(12'h044, 32'h8000_0001, "R6");
    doWrite(12'h048, 32'h0000_0001, "R6");
    chkPorts("R6 ports");
    doRead(12'h00C, "R6");
    doRead(12'h010, "R6");
    doRead(12'h040, "R6");

    // R7 event flags
    doWrite(12'h04C, 32'hFFFF_FFFF, "R7");
    @(negedge clk); evHit = 32'h0000_00F0;
    @(negedge clk); evHit = '0; mdl[19] = mdl[19] | 32'h0000_00F0;
    chk("R7 flag set", cfgEvFlag, mdl[19]);
    doWrite(12'h04C, 32'h0000_0030, "R7");
    chk("R7 flag clear", cfgEvFlag, 32'h0000_00C0);
    @(negedge clk);
    evHit = 32'h0000_0040; wrEn = 1'b1; addr = 12'h04C; wrData = 32'h0000_00C0;
    @(negedge clk);
    evHit = '0; wrEn = 1'b0;
    mdl[19] = 32'h0000_0040;
    chk("R7 hit beats clear", cfgEvFlag, mdl[19]);
    chk("R11 accepted clear", {31'd0, accErr}, 32'd0);

    // R10 odd addresses
    doRead(12'h101, "R10");
    doRead(12'h0A8, "R10");
    doWrite(12'h088, 32'hDEAD_BEEF, "R10");
    doWrite(12'h00A, 32'hDEAD_BEEF, "R10");
    doWrite(12'h050, 32'hDEAD_BEEF, "R10");
    chkPorts("R10 ports");

    // R3 arm via second key word
    doWrite(12'h07C, 32'h1111_1111, "R3");
    doRead(12'h000, "R3");
    doRead(12'h07C, "R8");

    // R4 locked sweep
    for (int i = 1; i < 31; i++) doWrite(12'(i * 4), 32'h0BAD_F00D ^ 32'(i), "R4");
    chkPorts("R4 ports");
    readAll("R4");

    // R5 unlock sequence
    doWrite(12'h000, 32'hC0DE_FA73, "R5 no arm key");
    doWrite(12'h07C, 32'hC0DE_1248, "R5 arm key");
    doWrite(12'h000, 32'hC0DE_FA72, "R5 wrong key");
    doWrite(12'h000, 32'hC0DE_FA73, "R5 good key");
    doRead(12'h000, "R5");
    doWrite(12'h008, 32'h7777_7777, "R5 writable again");
    chkPorts("R5 ports");
    doWrite(12'h000, 32'h0000_0000, "R3 arm via first key");
    doWrite(12'h000, 32'hC0DE_FA73, "R5 key cleared by arming");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule